// File: doc/BRIEF.md
# Data Memory Address Resolver

This block turns the 8-bit file-register operand of a byte-oriented or bit-oriented instruction into a 12-bit data-memory address. Each cycle it looks at the operand, the access-select bit and an extended-addressing enable. From these it chooses one of three paths:

- **Banked:** the operand sits inside a bank picked by a bank-select register.
- **Access:** the operand is a fixed-location access-bank address.
- **Indexed:** the operand is an offset added to a 12-bit frame pointer.

The destination bit of the instruction rides alongside unchanged, so the downstream write-back logic sees it in step with the address.

The bank-select register and the frame pointer live inside the block and are loaded through a one-word register-write port. The port has a select line that picks the target register. Address resolution is combinational from the operand inputs and the two registers. A register write therefore changes resolved addresses from the cycle after the write edge onward.

Top module: `data_addr_resolver`

## Requirements
- R1: With extended mode off and access bit 0, operands 00h..5Fh give addresses 000h..05Fh and operands 60h..FFh give F60h..FFFh. The path output reads 2'b01 (access).
- R2: With access bit 1, the address is {bank[3:0], operand} and the path output reads 2'b00 (banked), whether extended mode is on or off.
- R3: With extended mode on, access bit 0 and operand at most 5Fh, the address is frame pointer plus operand and the path output reads 2'b10 (indexed).
- R4: With extended mode on, access bit 0 and operand above 5Fh, the address follows the R1 access mapping and the path output reads 2'b01.
- R5: With the frame pointer at 000h, every indexed operand 00h..5Fh resolves to the same address as in R1.
- R6: The destination output always equals the destination input, in either mode and on every path.
- R7: A write with wr_sel_i=0 loads wr_data_i[3:0] into the bank register. A write with wr_sel_i=1 loads wr_data_i[11:0] into the frame pointer. Either value is used from the next clock edge onward, and the other register keeps its value.
- R8: A synchronous reset clears both the bank register and the frame pointer to zero.
- R9: The indexed sum is 12 bits wide and wraps modulo 4096 (for example, FF0h + 5Fh gives 04Fh).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opnd_i | input | 8 | File-register operand |
| acc_i | input | 1 | Access-select bit (1 = banked) |
| dest_i | input | 1 | Destination bit |
| ext_en_i | input | 1 | Extended addressing enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 bank register, 1 frame pointer |
| wr_data_i | input | 12 | Write data |
| addr_o | output | 12 | Resolved data-memory address |
| path_o | output | 2 | Path taken: 00 banked, 01 access, 10 indexed |
| dest_o | output | 1 | Destination bit, passed through |

## Verification
A wrong bank value appears in the upper address nibble of the first banked operand presented after the corrupting write. A wrong frame pointer shows up as an offset error on the first indexed operand. Both can be seen in the cycle after the edge that loaded them, because the address path holds no register. A mistaken path decision near the 5Fh/60h boundary shows at once on path_o and in the address's upper bits. The bench therefore probes both sides of that boundary in each mode, and it probes the 12-bit wrap of the indexed sum.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
  typedef enum logic [1:0] {
    PATH_BANKED  = 2'b00,
    PATH_ACCESS  = 2'b01,
    PATH_INDEXED = 2'b10
  } path_e;
endpackage

// File: rtl/dmar_regfile.sv
module dmar_regfile #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] fp_o
);
  logic bank_we, fp_we;
  assign bank_we = wr_en_i && !wr_sel_i;
  assign fp_we   = wr_en_i &&  wr_sel_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_o <= '0;
      fp_o   <= '0;
    end else begin
      if (bank_we) bank_o <= wr_data_i[BANK_W-1:0];
      if (fp_we)   fp_o   <= wr_data_i;
    end
  end

  // R7: each write lands on the next edge and leaves the other register alone
  p_bank_load_r7: assert property (@(posedge clk) disable iff (rst)
    bank_we |=> bank_o == $past(wr_data_i[BANK_W-1:0]));
  p_fp_load_r7: assert property (@(posedge clk) disable iff (rst)
    fp_we |=> fp_o == $past(wr_data_i));
  p_fp_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fp_we |=> $stable(fp_o));
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bank_we |=> $stable(bank_o));
endmodule

// File: rtl/dmar_path_sel.sv
module dmar_path_sel
  import dmar_pkg::*;
#(
  parameter int             OPND_W = 8,
  parameter logic [OPND_W-1:0] THRESH = 8'h5F
) (
  input  logic [OPND_W-1:0] opnd_i,
  input  logic              acc_i,
  input  logic              ext_en_i,
  output path_e             path_o,
  output logic              in_low_o
);
  function automatic path_e pick(input logic acc, input logic ext, input logic low);
    if (acc)             return PATH_BANKED;
    else if (ext && low) return PATH_INDEXED;
    else                 return PATH_ACCESS;
  endfunction

  assign in_low_o = (opnd_i <= THRESH);
  assign path_o   = pick(acc_i, ext_en_i, in_low_o);
endmodule

// File: rtl/dmar_addr_gen.sv
module dmar_addr_gen
  import dmar_pkg::*;
#(
  parameter int OPND_W = 8,
  parameter int ADDR_W = 12,
  parameter int BANK_W = 4
) (
  input  path_e             path_i,
  input  logic              in_low_i,
  input  logic [OPND_W-1:0] opnd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] fp_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int FILL_W = ADDR_W - OPND_W;

  function automatic logic [ADDR_W-1:0] access_map(input logic [OPND_W-1:0] op, input logic low);
    return low ? {{FILL_W{1'b0}}, op} : {{FILL_W{1'b1}}, op};
  endfunction

  function automatic logic [ADDR_W-1:0] banked_map(input logic [BANK_W-1:0] b, input logic [OPND_W-1:0] op);
    return {b, op};
  endfunction

  function automatic logic [ADDR_W-1:0] indexed_sum(input logic [ADDR_W-1:0] base, input logic [OPND_W-1:0] op);
    return base + {{FILL_W{1'b0}}, op};
  endfunction

  always_comb begin
    unique case (path_i)
      PATH_BANKED:  addr_o = banked_map(bank_i, opnd_i);
      PATH_INDEXED: addr_o = indexed_sum(fp_i, opnd_i);
      default:      addr_o = access_map(opnd_i, in_low_i);
    endcase
  end
endmodule

// File: rtl/data_addr_resolver.sv
module data_addr_resolver
  import dmar_pkg::*;
#(
  parameter int                OPND_W = 8,
  parameter int                ADDR_W = 12,
  parameter int                BANK_W = ADDR_W - OPND_W,
  parameter logic [OPND_W-1:0] THRESH = 8'h5F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPND_W-1:0] opnd_i,
  input  logic              acc_i,
  input  logic              dest_i,
  input  logic              ext_en_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        path_o,
  output logic              dest_o
);
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] fp_q;
  path_e             path_w;
  logic              in_low_w;

  dmar_regfile #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .bank_o(bank_q), .fp_o(fp_q));

  dmar_path_sel #(.OPND_W(OPND_W), .THRESH(THRESH)) u_sel (
    .opnd_i(opnd_i), .acc_i(acc_i), .ext_en_i(ext_en_i),
    .path_o(path_w), .in_low_o(in_low_w));

  dmar_addr_gen #(.OPND_W(OPND_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_gen (
    .path_i(path_w), .in_low_i(in_low_w), .opnd_i(opnd_i),
    .bank_i(bank_q), .fp_i(fp_q), .addr_o(addr_o));

  assign path_o = path_w;
  assign dest_o = dest_i;

  p_banked_r2: assert property (@(posedge clk) disable iff (rst)
    acc_i |-> (path_o == 2'b00) && (addr_o[ADDR_W-1:OPND_W] == bank_q)
              && (addr_o[OPND_W-1:0] == opnd_i));
  p_indexed_r3: assert property (@(posedge clk) disable iff (rst)
    (ext_en_i && !acc_i && opnd_i <= THRESH) |-> path_o == 2'b10);
  p_high_access_r4: assert property (@(posedge clk) disable iff (rst)
    (!acc_i && opnd_i > THRESH) |-> (path_o == 2'b01) && (&addr_o[ADDR_W-1:OPND_W]));
  p_low_access_r1: assert property (@(posedge clk) disable iff (rst)
    (!ext_en_i && !acc_i && opnd_i <= THRESH) |->
      (path_o == 2'b01) && (addr_o[ADDR_W-1:OPND_W] == '0));
  p_dest_pass_r6: assert property (@(posedge clk) disable iff (rst)
    dest_o == dest_i);
endmodule

// File: tb/data_addr_resolver_bench.sv
module data_addr_resolver_bench;
  logic clk = 0, rst = 1;
  logic [7:0] opnd = 0;
  logic acc = 0, dest = 0, ext = 0, wr_en = 0, wr_sel = 0;
  logic [11:0] wr_data = 0;
  logic [11:0] addr;
  logic [1:0] path;
  logic dest_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  data_addr_resolver u_data_addr_resolver (
    .clk(clk), .rst(rst), .opnd_i(opnd), .acc_i(acc), .dest_i(dest),
    .ext_en_i(ext), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .addr_o(addr), .path_o(path), .dest_o(dest_o));

  task automatic apply(input logic [7:0] o, input logic a, input logic e, input logic d);
    @(negedge clk); opnd = o; acc = a; ext = e; dest = d; #2;
  endtask

  task automatic check(input string req, input logic [11:0] ea, input logic [1:0] ep);
    n_chk++;
    if (addr !== ea || path !== ep) begin
      n_bad++;
      $display("FAIL %s: addr=%h path=%b expected addr=%h path=%b", req, addr, path, ea, ep);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [11:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_reset;   // R8
    rst = 1; repeat (2) @(negedge clk);
    apply(8'h3C, 1, 0, 0); check("R8 bank cleared", 12'h03C, 2'b00);
    apply(8'h20, 0, 1, 0); check("R8 fp cleared", 12'h020, 2'b10);
    rst = 0;
  endtask

  task automatic t_normal;  // R1
    apply(8'h00, 0, 0, 0); check("R1 low 00", 12'h000, 2'b01);
    apply(8'h5F, 0, 0, 0); check("R1 low 5F", 12'h05F, 2'b01);
    apply(8'h60, 0, 0, 0); check("R1 high 60", 12'hF60, 2'b01);
    apply(8'hFF, 0, 0, 0); check("R1 high FF", 12'hFFF, 2'b01);
  endtask

  task automatic t_banked;  // R2, R7
    write_reg(0, 12'hAB7);
    apply(8'h44, 1, 0, 0); check("R2/R7 bank ext off", 12'h744, 2'b00);
    apply(8'h10, 1, 1, 0); check("R2 bank ext on", 12'h710, 2'b00);
    apply(8'hF0, 1, 1, 0); check("R2 bank high opnd", 12'h7F0, 2'b00);
  endtask

  task automatic t_indexed; // R3, R4, R7
    write_reg(1, 12'h3A0);
    apply(8'h00, 0, 1, 0); check("R3 fp+00", 12'h3A0, 2'b10);
    apply(8'h5F, 0, 1, 0); check("R3 fp+5F", 12'h3FF, 2'b10);
    apply(8'h60, 0, 1, 0); check("R4 60 stays access", 12'hF60, 2'b01);
    apply(8'hC3, 0, 1, 0); check("R4 C3 stays access", 12'hFC3, 2'b01);
    apply(8'h22, 1, 1, 0); check("R7 bank kept after fp write", 12'h722, 2'b00);
    write_reg(0, 12'h005);
    apply(8'h11, 0, 1, 0); check("R7 fp kept after bank write", 12'h3B1, 2'b10);
    apply(8'h11, 1, 0, 0); check("R7 new bank", 12'h511, 2'b00);
  endtask

  task automatic t_zero_fp; // R5
    write_reg(1, 12'h000);
    for (int k = 0; k <= 8'h5F; k += 8'h17) begin
      apply(k[7:0], 0, 1, 0); check("R5 fp zero", {4'h0, k[7:0]}, 2'b10);
    end
  endtask

  task automatic t_wrap;    // R9
    write_reg(1, 12'hFF0);
    apply(8'h5F, 0, 1, 0); check("R9 wrap FF0+5F", 12'h04F, 2'b10);
    apply(8'h0F, 0, 1, 0); check("R9 no wrap FF0+0F", 12'hFFF, 2'b10);
  endtask

  task automatic t_dest;    // R6
    for (int m = 0; m < 4; m++) begin
      apply(8'h30, m[0], m[1], 1); n_chk++;
      if (dest_o !== 1'b1) begin n_bad++; $display("FAIL R6: dest=%b expected 1", dest_o); end
      apply(8'h30, m[0], m[1], 0); n_chk++;
      if (dest_o !== 1'b0) begin n_bad++; $display("FAIL R6: dest=%b expected 0", dest_o); end
    end
  endtask

  task automatic t_reset_again; // R8 after nonzero contents
    write_reg(0, 12'h00C);
    rst = 1; @(negedge clk); rst = 0;
    apply(8'h01, 1, 0, 0); check("R8 bank re-cleared", 12'h001, 2'b00);
    apply(8'h02, 0, 1, 0); check("R8 fp re-cleared", 12'h002, 2'b10);
  endtask

  initial begin
    t_reset; t_normal; t_banked; t_indexed; t_zero_fp; t_wrap; t_dest; t_reset_again;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule